// File: doc/BRIEF.md
# Stereo Automatic Level Control

This block controls the level of a stereo sample stream. Each strobe delivers one signed left and one signed right sample. From the larger of the two magnitudes the block updates one 8-bit gain code per channel, where one code step is 0.5 dB and a larger code means more gain. A sample close to full scale makes the limiter cut both gain codes at once. After a quiet stretch the recovery path raises both codes one small step at a time. Recovery never takes a code above the reference level input.

Gain changes can take effect on the strobe that caused them. They can also be held as pending until each channel's own sample sign flips, or until a fixed number of strobes has passed. A band of levels just below the limiter threshold holds off recovery without cutting gain. When the limiter fires only briefly, the wait before the next recovery is shortened. Software programs the behaviour through a single 8-bit control register.

Top module: `stereo_alc`

## Requirements
- R1: After synchronous reset both gain codes equal INIT_GAIN (default 0x80) and the control register reads 0x28.
- R2: A write to the control register stores data bits 5..0 on the next clock. Readback bits 7..6 are always 0. The bit meanings are: 5 = immediate update (zero-cross wait off), 4 = enable, 3 = fast recovery, 2 = level select, 1 = recovery step of 2, 0 = limiter step of 2.
- R3: While the enable bit is 0, both gain codes keep their values whatever samples arrive.
- R4: With level select 0 and 16-bit samples, a strobe whose larger channel magnitude is 30935 or more fires the limiter. 30934 does not fire it. The magnitude of a negative sample is its absolute value.
- R5: With level select 1, the limiter threshold is 26028. A magnitude of 26027 does not fire it.
- R6: The limiter lowers a gain code by 1 when bit 0 is 0 and by 2 when bit 0 is 1. The code saturates at 0.
- R7: Recovery raises a gain code by 1 when bit 1 is 0 and by 2 when bit 1 is 1. It happens on the 16th quiet strobe counted since the last limiter strobe, reset-band strobe or recovery. It never takes the code above ref_level and never lowers it.
- R8: A strobe in the reset band restarts the recovery count and does not change the gain. The band is 24572..30934 for level select 0 and 20675..26027 for level select 1.
- R9: With fast recovery on, a limiter run of 1 or 2 consecutive strobes makes the next recovery wait 4 quiet strobes. A run of 3 or more, or fast recovery off, leaves the wait at 16.
- R10: With bit 5 at 0, a channel's gain change stays pending. It is applied on a later strobe where that channel's sample sign differs from its previous sample's sign, independently per channel.
- R11: With bit 5 at 0 and no sign change, a pending change is forced on the 8th strobe after it was raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_din | input | 8 | Control register write data |
| ctrl_q | output | 8 | Control register readback |
| ref_level | input | 8 | Upper limit for recovery |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | DATA_W | Signed left sample |
| smp_right | input | DATA_W | Signed right sample |
| gain_left | output | 8 | Left gain code |
| gain_right | output | 8 | Right gain code |

## Verification
Directed sequences put magnitudes one below and exactly at each threshold. They separate the limiter threshold from the reset band under both level selections, and negative samples check the magnitude path. Short and long overload bursts show whether the recovery wait shrinks only after brief overloads. Sign patterns that differ between the channels show whether pending changes wait for each channel's own zero crossing or for the timeout. Random samples then mix loud, banded and quiet levels with random control and reference writes. The expected gain codes come from a bench model.

// File: rtl/alc_pkg.sv
package alc_pkg;

    localparam int GAIN_W = 8;
    localparam logic [7:0] CTRL_RST = 8'h28;

    // fractions of full scale scaled by 2^16
    localparam int K_LIM_LO  = 61870;  // -0.5 dBFS
    localparam int K_BAND_LO = 49145;  // -2.5 dBFS
    localparam int K_LIM_HI  = 52057;  // -2.0 dBFS
    localparam int K_BAND_HI = 41350;  // -4.0 dBFS

    typedef struct packed {
        logic [1:0] zero;
        logic       imm_upd;
        logic       enable;
        logic       fast_rec;
        logic       lvl_sel;
        logic       rec_two;
        logic       lim_two;
    } ctrl_t;

    typedef struct packed {
        logic over;
        logic band;
    } level_t;

    typedef enum logic [1:0] {ACT_NONE, ACT_CUT, ACT_RAISE} act_e;

    function automatic longint level_thr(int dw, int k);
        return ((longint'(1) << (dw - 1)) * longint'(k)) >> 16;
    endfunction

    function automatic logic [GAIN_W-1:0] gain_cut(logic [GAIN_W-1:0] g, logic two);
        logic [GAIN_W-1:0] st;
        st = two ? GAIN_W'(2) : GAIN_W'(1);
        return (g > st) ? g - st : '0;
    endfunction

    function automatic logic [GAIN_W-1:0] gain_raise(logic [GAIN_W-1:0] g, logic two,
                                                    logic [GAIN_W-1:0] lim);
        logic [GAIN_W:0] sum;
        sum = {1'b0, g} + (two ? (GAIN_W+1)'(2) : (GAIN_W+1)'(1));
        if (g >= lim) return g;
        return (sum > {1'b0, lim}) ? lim : sum[GAIN_W-1:0];
    endfunction

endpackage

// File: rtl/alc_detect.sv
module alc_detect #(
    parameter int DATA_W = 16
) (
    input  logic                     lvl_sel,
    input  logic signed [DATA_W-1:0] left,
    input  logic signed [DATA_W-1:0] right,
    output alc_pkg::level_t          lvl
);
    import alc_pkg::*;

    localparam int MAG_W = DATA_W + 1;
    localparam logic [MAG_W-1:0] LIM_LO  = MAG_W'(level_thr(DATA_W, K_LIM_LO));
    localparam logic [MAG_W-1:0] BAND_LO = MAG_W'(level_thr(DATA_W, K_BAND_LO));
    localparam logic [MAG_W-1:0] LIM_HI  = MAG_W'(level_thr(DATA_W, K_LIM_HI));
    localparam logic [MAG_W-1:0] BAND_HI = MAG_W'(level_thr(DATA_W, K_BAND_HI));

    function automatic logic [MAG_W-1:0] mag(logic [DATA_W-1:0] s);
        logic [MAG_W-1:0] e;
        e = {s[DATA_W-1], s};
        return s[DATA_W-1] ? (~e + 1'b1) : e;
    endfunction

    logic [MAG_W-1:0] m_l, m_r, peak, t_lim, t_band;

    always_comb begin
        m_l    = mag(left);
        m_r    = mag(right);
        peak   = (m_l > m_r) ? m_l : m_r;
        t_lim  = lvl_sel ? LIM_HI : LIM_LO;
        t_band = lvl_sel ? BAND_HI : BAND_LO;
        lvl.over = (peak >= t_lim);
        lvl.band = (peak >= t_band) && !lvl.over;
    end
endmodule

// File: rtl/alc_timer.sv
module alc_timer #(
    parameter int REC_PERIOD = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    input  logic            enable,
    input  logic            fast_en,
    input  alc_pkg::level_t lvl,
    output alc_pkg::act_e   act
);
    import alc_pkg::*;

    localparam int CNT_W = $clog2(REC_PERIOD + 1);
    localparam int FAST_PERIOD = (REC_PERIOD / 4 < 1) ? 1 : REC_PERIOD / 4;

    logic [CNT_W-1:0] wait_cnt;
    logic [1:0]       run_len;
    logic             fast_armed;
    logic [CNT_W:0]   period, cnt_nxt;

    always_comb begin
        period  = fast_armed ? (CNT_W+1)'(FAST_PERIOD) : (CNT_W+1)'(REC_PERIOD);
        cnt_nxt = {1'b0, wait_cnt} + 1'b1;
        act     = ACT_NONE;
        if (strobe && enable) begin
            if (lvl.over)
                act = ACT_CUT;
            else if (!lvl.band && cnt_nxt >= period)
                act = ACT_RAISE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            wait_cnt   <= '0;
            run_len    <= '0;
            fast_armed <= 1'b0;
        end else if (strobe) begin
            if (lvl.over) begin
                wait_cnt   <= '0;
                run_len    <= (run_len == 2'd3) ? 2'd3 : run_len + 2'd1;
                fast_armed <= 1'b0;
            end else begin
                if (run_len != 2'd0) begin
                    run_len    <= '0;
                    fast_armed <= fast_en && (run_len <= 2'd2);
                end
                if (lvl.band)
                    wait_cnt <= '0;
                else if (act == ACT_RAISE) begin
                    wait_cnt   <= '0;
                    fast_armed <= 1'b0;
                end else
                    wait_cnt <= cnt_nxt[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/alc_gain_ch.sv
module alc_gain_ch #(
    parameter int ZC_TIMEOUT = 8,
    parameter logic [7:0] INIT_GAIN = 8'h80
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          enable,
    input  logic          zc_wait,
    input  alc_pkg::act_e act,
    input  logic          lim_two,
    input  logic          rec_two,
    input  logic [7:0]    ref_lvl,
    input  logic          sign,
    output logic [7:0]    gain
);
    import alc_pkg::*;

    localparam int TC_W = (ZC_TIMEOUT > 1) ? $clog2(ZC_TIMEOUT) : 1;
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(ZC_TIMEOUT - 1);

    logic [7:0]      target, base, nxt;
    logic            pend, prev_sign, fire;
    logic [TC_W-1:0] tcnt;

    always_comb begin
        base = (zc_wait && pend) ? target : gain;
        case (act)
            ACT_CUT:   nxt = gain_cut(base, lim_two);
            ACT_RAISE: nxt = gain_raise(base, rec_two, ref_lvl);
            default:   nxt = base;
        endcase
        fire = pend && ((sign != prev_sign) || (tcnt == TC_LAST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain      <= INIT_GAIN;
            target    <= INIT_GAIN;
            pend      <= 1'b0;
            tcnt      <= '0;
            prev_sign <= 1'b0;
        end else begin
            if (strobe)
                prev_sign <= sign;
            if (!enable || !zc_wait) begin
                pend <= 1'b0;
                tcnt <= '0;
                if (strobe && enable && act != ACT_NONE)
                    gain <= nxt;
            end else if (strobe) begin
                if (fire) begin
                    gain <= (act != ACT_NONE) ? nxt : target;
                    pend <= 1'b0;
                    tcnt <= '0;
                end else if (act != ACT_NONE) begin
                    target <= nxt;
                    tcnt   <= pend ? tcnt + 1'b1 : '0;
                    pend   <= 1'b1;
                end else if (pend)
                    tcnt <= tcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stereo_alc.sv
module stereo_alc #(
    parameter int DATA_W = 16,
    parameter int REC_PERIOD = 16,
    parameter int ZC_TIMEOUT = 8,
    parameter logic [7:0] INIT_GAIN = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ctrl_we,
    input  logic [7:0]               ctrl_din,
    output logic [7:0]               ctrl_q,
    input  logic [7:0]               ref_level,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_left,
    input  logic signed [DATA_W-1:0] smp_right,
    output logic [7:0]               gain_left,
    output logic [7:0]               gain_right
);
    import alc_pkg::*;

    localparam int NCH = 2;

    ctrl_t      ctrl;
    level_t     lvl;
    act_e       act;
    logic [NCH-1:0] sgn;
    logic [7:0] gains [NCH];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= ctrl_t'(CTRL_RST);
        else if (ctrl_we)
            ctrl <= ctrl_t'({2'b00, ctrl_din[5:0]});
    end

    assign ctrl_q = ctrl;
    assign sgn    = {smp_right[DATA_W-1], smp_left[DATA_W-1]};

    alc_detect #(.DATA_W(DATA_W)) u_det (
        .lvl_sel (ctrl.lvl_sel),
        .left    (smp_left),
        .right   (smp_right),
        .lvl     (lvl)
    );

    alc_timer #(.REC_PERIOD(REC_PERIOD)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .strobe  (smp_valid),
        .enable  (ctrl.enable),
        .fast_en (ctrl.fast_rec),
        .lvl     (lvl),
        .act     (act)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        alc_gain_ch #(.ZC_TIMEOUT(ZC_TIMEOUT), .INIT_GAIN(INIT_GAIN)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .strobe  (smp_valid),
            .enable  (ctrl.enable),
            .zc_wait (!ctrl.imm_upd),
            .act     (act),
            .lim_two (ctrl.lim_two),
            .rec_two (ctrl.rec_two),
            .ref_lvl (ref_level),
            .sign    (sgn[c]),
            .gain    (gains[c])
        );
    end

    assign gain_left  = gains[0];
    assign gain_right = gains[1];
endmodule

// File: rtl/stereo_alc_chk.sv
module stereo_alc_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_we,
    input logic [7:0] ctrl_din,
    input logic [7:0] ctrl_q,
    input logic [7:0] ref_level,
    input logic       smp_valid,
    input logic [7:0] gain_left,
    input logic [7:0] gain_right
);
    // R2: written bits appear on the next clock
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> ctrl_q[5:0] == $past(ctrl_din[5:0]));

    // R3: disabled engine leaves both gains alone
    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[4] |=> ($stable(gain_left) && $stable(gain_right)));

    // R7: gains move only on a sample strobe
    a_r7_no_strobe_no_move: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(gain_left) && $stable(gain_right)));

    // R6: immediate mode moves a gain by at most two codes per strobe
    a_r6_step_bound: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[5] |=> (({1'b0, gain_left} + 9'd2 >= {1'b0, $past(gain_left)}) &&
                       ({1'b0, gain_left} <= {1'b0, $past(gain_left)} + 9'd2)));

    // R7: an increase in immediate mode never passes the reference
    a_r7_ref_cap: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[5] |=> ((gain_right <= $past(gain_right)) || (gain_right <= $past(ref_level))));
endmodule

bind stereo_alc stereo_alc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_din   (ctrl_din),
    .ctrl_q     (ctrl_q),
    .ref_level  (ref_level),
    .smp_valid  (smp_valid),
    .gain_left  (gain_left),
    .gain_right (gain_right)
);

// File: tb/stereo_alc_tb.sv
`timescale 1ns/1ps
module stereo_alc_tb;
    logic clk = 0, rst = 1;
    logic ctrl_we = 0;
    logic [7:0] ctrl_din = 0, ctrl_q, ref_level = 8'hA0;
    logic smp_valid = 0;
    logic signed [15:0] smp_left = 0, smp_right = 0;
    logic [7:0] gain_left, gain_right;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stereo_alc u_dut (.*);

    // bench model state
    int m_gain[2], m_tgt[2], m_tc[2];
    bit m_pend[2], m_prev[2];
    int m_wait, m_run;
    bit m_fast;
    int m_ctrl;

    task automatic check(string req, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act_v, exp_v);
        end
    endtask

    function automatic int nxt_gain(int g, int act);
        int st;
        if (act == 1) begin
            st = m_ctrl[0] ? 2 : 1;
            return (g > st) ? g - st : 0;
        end
        if (act == 2) begin
            st = m_ctrl[1] ? 2 : 1;
            if (g >= int'(ref_level)) return g;
            return (g + st > int'(ref_level)) ? int'(ref_level) : g + st;
        end
        return g;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_gain[c] = 8'h80; m_tgt[c] = 8'h80; m_tc[c] = 0; m_pend[c] = 0; m_prev[c] = 0;
        end
        m_wait = 0; m_run = 0; m_fast = 0; m_ctrl = 8'h28;
    endtask

    task automatic model_step(int l, int r);
        int ml, mr, pk, tl, tb, act, period, s[2], base, nx;
        bit en, imm, fire, over, band;
        en  = m_ctrl[4];
        imm = m_ctrl[5];
        ml = (l < 0) ? -l : l;
        mr = (r < 0) ? -r : r;
        pk = (ml > mr) ? ml : mr;
        tl = m_ctrl[2] ? 26028 : 30935;
        tb = m_ctrl[2] ? 20675 : 24572;
        over = pk >= tl;
        band = (pk >= tb) && !over;
        act = 0;
        if (en) begin
            period = m_fast ? 4 : 16;
            if (over) begin
                act = 1; m_wait = 0; m_fast = 0;
                m_run = (m_run == 3) ? 3 : m_run + 1;
            end else begin
                if (m_run != 0) begin m_fast = m_ctrl[3] && (m_run <= 2); m_run = 0; end
                if (band) m_wait = 0;
                else if (m_wait + 1 >= period) begin act = 2; m_wait = 0; m_fast = 0; end
                else m_wait++;
            end
        end
        s[0] = (l < 0); s[1] = (r < 0);
        for (int c = 0; c < 2; c++) begin
            if (!en || imm) begin
                m_pend[c] = 0; m_tc[c] = 0;
                if (en && act != 0) m_gain[c] = nxt_gain(m_gain[c], act);
            end else begin
                base = m_pend[c] ? m_tgt[c] : m_gain[c];
                nx = nxt_gain(base, act);
                fire = m_pend[c] && ((s[c] != 0) != m_prev[c] || m_tc[c] == 7);
                if (fire) begin
                    m_gain[c] = (act != 0) ? nx : m_tgt[c];
                    m_pend[c] = 0; m_tc[c] = 0;
                end else if (act != 0) begin
                    m_tgt[c] = nx;
                    m_tc[c] = m_pend[c] ? m_tc[c] + 1 : 0;
                    m_pend[c] = 1;
                end else if (m_pend[c]) m_tc[c]++;
            end
            m_prev[c] = (s[c] != 0);
        end
    endtask

    task automatic wr_ctrl(int d);
        @(negedge clk);
        ctrl_we = 1; ctrl_din = 8'(d);
        @(negedge clk);
        ctrl_we = 0;
        m_ctrl = d & 8'h3F;
        if (!m_ctrl[4]) begin
            m_wait = 0; m_run = 0; m_fast = 0;
        end
        if (!m_ctrl[4] || m_ctrl[5]) begin
            m_pend = '{0, 0}; m_tc = '{0, 0};
        end
    endtask

    task automatic strobe(int l, int r, string req);
        @(negedge clk);
        smp_valid = 1; smp_left = 16'(l); smp_right = 16'(r);
        @(negedge clk);
        smp_valid = 0;
        model_step(l, r);
        check({req, " left"},  gain_left,  m_gain[0]);
        check({req, " right"}, gain_right, m_gain[1]);
    endtask

    task automatic quiet(int n, string req);
        for (int i = 0; i < n; i++) strobe(100, 90, req);
    endtask

    function automatic int pick_level();
        int k;
        k = $urandom_range(0, 9);
        case (k)
            0, 1: return $urandom_range(26000, 32767);
            2, 3: return $urandom_range(20000, 31000);
            default: return $urandom_range(0, 18000);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset gain left", gain_left, 8'h80);
        check("R1 reset gain right", gain_right, 8'h80);
        check("R1 reset ctrl", ctrl_q, 8'h28);

        wr_ctrl(8'hFF);
        check("R2 readback masks top bits", ctrl_q, 8'h3F);
        wr_ctrl(8'h08);
        check("R2 readback", ctrl_q, 8'h08);
        strobe(32767, -32768, "R3 disabled");
        check("R3 gain held", gain_left, 8'h80);

        wr_ctrl(8'h30);
        strobe(30934, 0, "R4 below threshold");
        check("R4 no cut at 30934", gain_left, 8'h80);
        strobe(-30935, 5, "R4 at threshold");
        check("R4 cut at -30935", gain_right, 8'h7F);
        wr_ctrl(8'h31);
        strobe(100, 32767, "R6 step two");
        check("R6 cut by two", gain_left, 8'h7D);
        wr_ctrl(8'h34);
        strobe(26027, 0, "R5 below threshold");
        check("R5 no cut at 26027", gain_left, 8'h7D);
        strobe(0, 26028, "R5 at threshold");
        check("R5 cut at 26028", gain_left, 8'h7C);

        ref_level = 8'h7E;
        wr_ctrl(8'h32);
        quiet(15, "R7 waiting");
        check("R7 no raise before 16", gain_left, 8'h7C);
        quiet(1, "R7 raise");
        check("R7 raise by two", gain_left, 8'h7E);
        quiet(16, "R7 cap");
        check("R7 capped at ref", gain_right, 8'h7E);

        wr_ctrl(8'h38);
        strobe(32767, 0, "R9 short burst");
        quiet(3, "R9 short wait");
        check("R9 no raise after 3", gain_left, 8'h7D);
        quiet(1, "R9 fast raise");
        check("R9 raise after 4", gain_left, 8'h7E);
        strobe(32767, 0, "R9 long burst");
        strobe(32767, 0, "R9 long burst");
        strobe(32767, 0, "R9 long burst");
        quiet(4, "R9 long wait");
        check("R9 no fast raise after 3-run", gain_left, 8'h7B);
        quiet(12, "R9 normal raise");
        check("R9 normal raise at 16", gain_left, 8'h7C);

        wr_ctrl(8'h30);
        quiet(10, "R8 count");
        strobe(25000, 0, "R8 band hit");
        quiet(15, "R8 restarted");
        check("R8 band restarts wait", gain_left, 8'h7C);
        quiet(1, "R8 raise");
        check("R8 raise after restart", gain_left, 8'h7D);

        wr_ctrl(8'h10);
        strobe(32767, 100, "R10 raise pending");
        check("R10 pending left", gain_left, 8'h7D);
        strobe(-50, 60, "R10 left crosses");
        check("R10 left applied", gain_left, 8'h7C);
        check("R10 right still pending", gain_right, 8'h7D);
        strobe(-40, -30, "R10 right crosses");
        check("R10 right applied", gain_right, 8'h7C);

        strobe(32767, 32767, "R11 raise pending");
        for (int i = 0; i < 7; i++) strobe(200, 300, "R11 waiting");
        check("R11 not yet forced", gain_left, 8'h7C);
        strobe(200, 300, "R11 timeout");
        check("R11 forced left", gain_left, 8'h7B);
        check("R11 forced right", gain_right, 8'h7B);

        for (int i = 0; i < 2500; i++) begin
            if ($urandom_range(0, 39) == 0)
                wr_ctrl($urandom_range(0, 255) | 8'h10);
            if ($urandom_range(0, 99) == 0)
                ref_level = 8'($urandom_range(8'h60, 8'hC0));
            strobe(($urandom_range(0, 1) ? -1 : 1) * pick_level(),
                   ($urandom_range(0, 1) ? -1 : 1) * pick_level(),
                   "R4 R6 R7 R8 R9 R10 R11 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule